// File: doc/BRIEF.md
# Two-round SHA-512 compression update

This unit performs the part of a SHA-512 compression step that evaluates the big Sigma1 rotation term and the choose term for two rounds in a row, folded into a single 128-bit operation. Three 128-bit operands arrive together: `X` and `Y` carry working-variable pairs, and `W` is an accumulator that the result replaces. Each operand is split into an upper and a lower 64-bit lane. The upper result lane is computed first. Its sum with the lower lane of `Y` then forms an intermediate value that drives the second round, which produces the lower result lane.

Operations enter through a valid/ready handshake and leave through another. The datapath is cut into two register stages, so every accepted operation returns after a fixed two-cycle latency that never depends on the operand values. The unit takes one operation per cycle for as long as the consumer keeps accepting results. A separate combinational decoder checks a 32-bit instruction word against the fixed opcode pattern of this operation and passes out its three register-index fields.

Top module: `sha2x_round_unit`

## Requirements
- R1: Sigma1(v) of a 64-bit value is the XOR of v rotated right by 14, by 18 and by 41 bit positions.
- R2: The upper result lane (bits 127:64) equals Ch(Y[127:64], X[63:0], X[127:64]) + Sigma1(Y[127:64]) + W[127:64], where Ch(e,f,g) = (e AND f) XOR (NOT e AND g).
- R3: With t = upper result lane + Y[63:0], the lower result lane (bits 63:0) equals Ch(t, Y[127:64], X[63:0]) + Sigma1(t) + W[63:0].
- R4: Every sum wraps modulo 2^64 inside its lane, and no carry passes between the lanes.
- R5: An operation accepted at a rising edge shows on `out_valid`/`out_result` after the second rising edge that follows it, provided `out_ready` is high in between, whatever the operand values.
- R6: `in_ready` is high in every cycle where the output stage is empty or `out_ready` is high, so a continuous stream is accepted at one operation per cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` holds its value.
- R8: A synchronous active-low reset empties both stages: after a reset edge `out_valid` is low and `in_ready` is high, and any operations that were in flight are discarded.
- R9: `insn_hit` is high exactly when `insn_word[31:21]` equals 11001110011 and `insn_word[15:10]` equals 100000. Any other value in those bits clears it.
- R10: `idx_m`, `idx_n` and `idx_d` equal `insn_word[20:16]`, `insn_word[9:5]` and `insn_word[4:0]` for any instruction word.
- R11: Each accepted operation yields exactly one result, in acceptance order, and no result appears without an accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is offered on `in_x`, `in_y` and `in_w` |
| in_ready | output | 1 | The unit takes the offered operation at this edge |
| in_x | input | 128 | Operand X (upper lane 127:64, lower lane 63:0) |
| in_y | input | 128 | Operand Y (upper lane 127:64, lower lane 63:0) |
| in_w | input | 128 | Accumulator W that the result replaces |
| out_valid | output | 1 | `out_result` holds a finished result |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_result | output | 128 | New accumulator value |
| insn_word | input | 32 | Instruction word to classify |
| insn_hit | output | 1 | The instruction word carries this operation's opcode |
| idx_m | output | 5 | Register index from bits 20:16 |
| idx_n | output | 5 | Register index from bits 9:5 |
| idx_d | output | 5 | Register index from bits 4:0 |

## Verification
The hardest situation to reach from the ports is a finished result held in the output stage by a low `out_ready` while a second operation sits in the first stage and a third one is offered at the input. Only in that case do the stall, the hold of the result and the refusal at the input all act in the same cycle. The random stimulus reaches it by lowering `out_ready` in about a third of the cycles while `in_valid` stays high most of the time. The directed operands are chosen so that the upper-lane sum, the intermediate value and the lower-lane sum each wrap past 2^64, which exposes any carry that leaks between the lanes. A reset issued while both stages hold data shows that the operations in flight are discarded.

// File: rtl/sha2x_pkg.sv
// Package: shared lane types, rotation distances, opcode layout and the
// round functions used by both pipeline stages of the two-round update.
// Assumes a 64-bit lane; the rotation distances are only meaningful there.
package sha2x_pkg;

    parameter int LANE_W = 64;
    localparam int VEC_W = 2 * LANE_W;

    parameter int ROT_A = 14;
    parameter int ROT_B = 18;
    parameter int ROT_C = 41;

    parameter int INSN_W      = 32;
    parameter int IDX_W       = 5;
    parameter int IDX_D_LSB   = 0;
    parameter int IDX_N_LSB   = IDX_D_LSB + IDX_W;
    parameter int OPC_MID_LSB = IDX_N_LSB + IDX_W;
    parameter int OPC_MID_W   = 6;
    parameter int IDX_M_LSB   = OPC_MID_LSB + OPC_MID_W;
    parameter int OPC_HI_LSB  = IDX_M_LSB + IDX_W;
    localparam int OPC_HI_W   = INSN_W - OPC_HI_LSB;

    localparam logic [OPC_HI_W-1:0]  OPC_HI_VAL  = 11'b11001110011;
    localparam logic [OPC_MID_W-1:0] OPC_MID_VAL = 6'b100000;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } vec_t;

    // Rotate a lane right by n positions (0 < n < LANE_W).
    function automatic lane_t rotr(input lane_t v, input int unsigned n);
        return (v >> n) | (v << (LANE_W - n));
    endfunction

    // Big Sigma1: XOR of three right rotations.
    function automatic lane_t sigma1_big(input lane_t v);
        return rotr(v, ROT_A) ^ rotr(v, ROT_B) ^ rotr(v, ROT_C);
    endfunction

    // Choose: bits of f where e is set, bits of g elsewhere.
    function automatic lane_t choose(input lane_t e, input lane_t f, input lane_t g);
        return (e & f) ^ (~e & g);
    endfunction

endpackage

// File: rtl/sha2x_hi_lane.sv
// First-round logic: computes the upper result lane from the operands and
// the chained intermediate value used by the second round.
// Assumes: purely combinational; every sum wraps within one lane.
module sha2x_hi_lane
    import sha2x_pkg::*;
(
    input  lane_t x_hi,
    input  lane_t x_lo,
    input  lane_t y_hi,
    input  lane_t y_lo,
    input  lane_t w_hi,
    output lane_t hi_sum,
    output lane_t chain_val
);

    lane_t ch_term;
    lane_t sig_term;

    // Round-one terms and the upper lane sum.
    always_comb begin
        ch_term   = choose(y_hi, x_lo, x_hi);
        sig_term  = sigma1_big(y_hi);
        hi_sum    = ch_term + sig_term + w_hi;
        chain_val = hi_sum + y_lo;
    end

endmodule

// File: rtl/sha2x_lo_lane.sv
// Second-round logic: computes the lower result lane from the chained
// intermediate value and the first-stage copies of the operands it needs.
// Assumes: purely combinational; the sum wraps within one lane.
module sha2x_lo_lane
    import sha2x_pkg::*;
(
    input  lane_t chain_val,
    input  lane_t y_hi,
    input  lane_t x_lo,
    input  lane_t w_lo,
    output lane_t lo_sum
);

    lane_t ch_term;
    lane_t sig_term;

    // Round-two terms and the lower lane sum.
    always_comb begin
        ch_term  = choose(chain_val, y_hi, x_lo);
        sig_term = sigma1_big(chain_val);
        lo_sum   = ch_term + sig_term + w_lo;
    end

endmodule

// File: rtl/sha2x_opmatch.sv
// Instruction classifier: flags a word whose fixed opcode fields match this
// operation and splits out its three register-index fields unchanged.
// Assumes: purely combinational; the index fields never affect the match.
module sha2x_opmatch
    import sha2x_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              hit,
    output logic [IDX_W-1:0]  idx_m,
    output logic [IDX_W-1:0]  idx_n,
    output logic [IDX_W-1:0]  idx_d
);

    logic hi_match;
    logic mid_match;

    // Compare both fixed opcode fields and slice out the indices.
    always_comb begin
        hi_match  = (insn[OPC_HI_LSB +: OPC_HI_W] == OPC_HI_VAL);
        mid_match = (insn[OPC_MID_LSB +: OPC_MID_W] == OPC_MID_VAL);
        hit       = hi_match & mid_match;
        idx_m     = insn[IDX_M_LSB +: IDX_W];
        idx_n     = insn[IDX_N_LSB +: IDX_W];
        idx_d     = insn[IDX_D_LSB +: IDX_W];
    end

endmodule

// File: rtl/sha2x_round_unit.sv
// Top: two-stage pipelined two-round SHA-512 update with valid/ready at both
// ends, plus an optional opcode classifier. Stage 1 registers the upper lane
// and the chained value; stage 2 registers the full result. Both stages move
// together whenever the output stage is empty or being drained.
// Assumes: synchronous active-low reset clears the valid flags only; data
// registers load only when a valid item moves into them.
module sha2x_round_unit
    import sha2x_pkg::*;
#(
    parameter bit HAS_DECODE = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_x,
    input  logic [VEC_W-1:0]  in_y,
    input  logic [VEC_W-1:0]  in_w,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  out_result,
    input  logic [INSN_W-1:0] insn_word,
    output logic              insn_hit,
    output logic [IDX_W-1:0]  idx_m,
    output logic [IDX_W-1:0]  idx_n,
    output logic [IDX_W-1:0]  idx_d
);

    vec_t  op_x;
    vec_t  op_y;
    vec_t  op_w;
    lane_t hi_comb;
    lane_t chain_comb;
    lane_t lo_comb;
    logic  advance;

    logic  s1_valid;
    lane_t s1_hi;
    lane_t s1_chain;
    lane_t s1_y_hi;
    lane_t s1_x_lo;
    lane_t s1_w_lo;

    logic  s2_valid;
    vec_t  s2_result;

    // View the flat operand ports as lane pairs.
    always_comb begin
        op_x = vec_t'(in_x);
        op_y = vec_t'(in_y);
        op_w = vec_t'(in_w);
    end

    // The whole pipe moves when the output stage can take a new entry.
    always_comb begin
        advance  = !s2_valid || out_ready;
        in_ready = advance;
    end

    sha2x_hi_lane u_hi (
        .x_hi      (op_x.hi),
        .x_lo      (op_x.lo),
        .y_hi      (op_y.hi),
        .y_lo      (op_y.lo),
        .w_hi      (op_w.hi),
        .hi_sum    (hi_comb),
        .chain_val (chain_comb)
    );

    // Stage 1 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else if (advance) begin
            s1_valid <= in_valid;
        end
    end

    // Stage 1 data: upper lane, chained value and operands for round two.
    always_ff @(posedge clk) begin
        if (advance && in_valid) begin
            s1_hi    <= hi_comb;
            s1_chain <= chain_comb;
            s1_y_hi  <= op_y.hi;
            s1_x_lo  <= op_x.lo;
            s1_w_lo  <= op_w.lo;
        end
    end

    sha2x_lo_lane u_lo (
        .chain_val (s1_chain),
        .y_hi      (s1_y_hi),
        .x_lo      (s1_x_lo),
        .w_lo      (s1_w_lo),
        .lo_sum    (lo_comb)
    );

    // Stage 2 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
        end else if (advance) begin
            s2_valid <= s1_valid;
        end
    end

    // Stage 2 data: assemble the finished result.
    always_ff @(posedge clk) begin
        if (advance && s1_valid) begin
            s2_result.hi <= s1_hi;
            s2_result.lo <= lo_comb;
        end
    end

    // Drive the output port pair from stage 2.
    always_comb begin
        out_valid  = s2_valid;
        out_result = s2_result;
    end

    generate
        if (HAS_DECODE) begin : g_decode
            sha2x_opmatch u_match (
                .insn  (insn_word),
                .hit   (insn_hit),
                .idx_m (idx_m),
                .idx_n (idx_n),
                .idx_d (idx_d)
            );
        end else begin : g_no_decode
            // Classifier absent: tie its outputs low.
            always_comb begin
                insn_hit = 1'b0;
                idx_m    = '0;
                idx_n    = '0;
                idx_d    = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/sha2x_round_chk.sv
// Checker: handshake and timing properties of the two-round update unit,
// attached to every instance of the top through the bind below.
// Assumes: sampled on the rising clock edge, reset synchronous and active low.
module sha2x_round_chk
    import sha2x_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_result
);

    logic rst_seen_q;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // After a reset edge the pipe is empty and open.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_EMPTY: assert (!out_valid && in_ready) else $error("pipe not empty after reset"); // R8
        end
    end

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_result))) else $error("result dropped or changed under backpressure"); // R7

    AST_READY_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) out_ready |-> in_ready) else $error("input refused while output drains"); // R6

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) ((in_valid && in_ready) ##1 in_ready) |=> out_valid) else $error("result late"); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> $past(in_valid && in_ready, 2)) else $error("result without accepted operation"); // R11

endmodule

bind sha2x_round_unit sha2x_round_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
);

// File: tb/sha2x_round_unit_bench.sv
// Bench: directed corner operands and seeded random traffic with random
// backpressure, checked against a lane model built from the requirements.
module sha2x_round_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int SEED       = 32'h5eed_0a17;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_x;
    logic [127:0] in_y;
    logic [127:0] in_w;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_result;
    logic [31:0]  insn_word;
    logic         insn_hit;
    logic [4:0]   idx_m;
    logic [4:0]   idx_n;
    logic [4:0]   idx_d;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit lat_mode = 1'b0;
    bit prev_hold = 1'b0;
    logic [127:0] prev_res;
    logic [127:0] exp_q[$];
    int           acc_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sha2x_round_unit u_sha2x_round_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_x       (in_x),
        .in_y       (in_y),
        .in_w       (in_w),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .insn_word  (insn_word),
        .insn_hit   (insn_hit),
        .idx_m      (idx_m),
        .idx_n      (idx_n),
        .idx_d      (idx_d)
    );

    function automatic logic [63:0] m_ror(input logic [63:0] v, input int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    // R1 rotation triple
    function automatic logic [63:0] m_sig(input logic [63:0] v);
        return m_ror(v, 14) ^ m_ror(v, 18) ^ m_ror(v, 41);
    endfunction

    function automatic logic [63:0] m_ch(input logic [63:0] e, input logic [63:0] f, input logic [63:0] g);
        return (e & f) ^ (~e & g);
    endfunction

    // R2 upper lane, R3 chained lower lane, R4 64-bit wrap per lane
    function automatic logic [127:0] m_model(input logic [127:0] x, input logic [127:0] y, input logic [127:0] w);
        logic [63:0] hi;
        logic [63:0] t;
        logic [63:0] lo;
        hi = m_ch(y[127:64], x[63:0], x[127:64]) + m_sig(y[127:64]) + w[127:64];
        t  = hi + y[63:0];
        lo = m_ch(t, y[127:64], x[63:0]) + m_sig(t) + w[63:0];
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Monitor: all inputs and outputs are stable at the falling edge.
    always @(negedge clk) begin : mon
        logic [127:0] e;
        int           a;
        cyc++;
        if (!rst_n) begin
            exp_q.delete();
            acc_q.delete();
            prev_hold = 1'b0;
        end else begin
            chk(in_ready === (!out_valid || out_ready), "R6 ready while output empty or draining",
                128'(in_ready), 128'(!out_valid || out_ready));
            if (prev_hold)
                chk(out_valid === 1'b1 && out_result === prev_res, "R7 result held under backpressure",
                    out_result, prev_res);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 result without accepted operation", out_result, '0);
                end else begin
                    e = exp_q.pop_front();
                    a = acc_q.pop_front();
                    chk(out_result === e, "R2 R3 R4 lane result in order (R11)", out_result, e);
                    if (lat_mode)
                        chk(cyc - a == 2, "R5 fixed two-cycle latency", 128'(cyc - a), 128'd2);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(m_model(in_x, in_y, in_w));
                acc_q.push_back(cyc);
            end
            prev_hold = out_valid && !out_ready;
            prev_res  = out_result;
        end
    end

    task automatic put(input logic v, input logic [127:0] x, input logic [127:0] y,
                       input logic [127:0] w, input logic r);
        @(posedge clk);
        #1;
        in_valid  = v;
        in_x      = x;
        in_y      = y;
        in_w      = w;
        out_ready = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, '0, '0, '0, 1'b1);
    endtask

    task automatic decode_one(input logic [31:0] word);
        logic hit_exp;
        insn_word = word;
        #1;
        hit_exp = (word[31:21] == 11'b11001110011) && (word[15:10] == 6'b100000);
        chk(insn_hit === hit_exp, "R9 opcode match", 128'(insn_hit), 128'(hit_exp));
        chk(idx_m === word[20:16] && idx_n === word[9:5] && idx_d === word[4:0],
            "R10 index fields", {idx_m, idx_n, idx_d}, {word[20:16], word[9:5], word[4:0]});
    endtask

    task automatic run_all();
        logic [127:0] ones;
        logic [31:0]  base;
        ones = '1;
        void'($urandom(SEED));
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_w = '0;
        out_ready = 1'b1; insn_word = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid === 1'b0, "R8 out_valid low after reset", 128'(out_valid), 128'd0);
        chk(in_ready === 1'b1, "R8 in_ready high after reset", 128'(in_ready), 128'd1);
        rst_n = 1'b1;

        // Directed corners with the output always accepted (R5 latency timed).
        lat_mode = 1'b1;
        put(1'b1, '0, '0, '0, 1'b1);
        put(1'b1, ones, ones, ones, 1'b1);
        put(1'b1, ones, '0, ones, 1'b1);
        put(1'b1, '0, ones, '0, 1'b1);
        put(1'b1, {2{64'h5555_aaaa_5555_aaaa}}, {64'haaaa_5555_aaaa_5555, 64'hffff_ffff_ffff_ffff},
            {64'hffff_ffff_ffff_fff0, 64'hffff_ffff_ffff_ffff}, 1'b1);
        put(1'b1, {64'h0, 64'hffff_ffff_ffff_ffff}, {64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ffff},
            {64'hffff_ffff_ffff_ffff, 64'h1}, 1'b1);
        put(1'b1, {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210}, {64'h1, 64'h8000_0000_0000_0000},
            {64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000}, 1'b1);
        idle(4);
        chk(128'(exp_q.size()) == 0, "R11 directed results all returned", 128'(exp_q.size()), 128'd0);

        // Back-to-back stream: one per cycle (R6) with timed latency (R5).
        for (int i = 0; i < 24; i++) put(1'b1, rnd128(), rnd128(), rnd128(), 1'b1);
        idle(4);
        lat_mode = 1'b0;

        // Random traffic with random backpressure (R7, R11).
        for (int i = 0; i < 3000; i++)
            put(($urandom % 4) != 0, rnd128(), rnd128(), rnd128(), ($urandom % 3) != 0);
        idle(6);
        chk(128'(exp_q.size()) == 0, "R11 every accepted operation returned", 128'(exp_q.size()), 128'd0);

        // Reset with both stages full (R8).
        for (int i = 0; i < 3; i++) put(1'b1, rnd128(), rnd128(), rnd128(), 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(out_valid === 1'b0, "R8 in-flight work discarded", 128'(out_valid), 128'd0);
        chk(in_ready === 1'b1, "R8 input open after reset", 128'(in_ready), 128'd1);
        rst_n = 1'b1;
        out_ready = 1'b1;
        put(1'b1, ones, {64'h0, ones[63:0]}, '0, 1'b1);
        idle(4);
        chk(128'(exp_q.size()) == 0, "R8 R11 only post-reset result returned", 128'(exp_q.size()), 128'd0);

        // Decoder (R9, R10).
        base = {11'b11001110011, 5'd19, 6'b100000, 5'd7, 5'd30};
        decode_one(base);
        for (int b = 0; b < 32; b++)
            if (b >= 21 || (b >= 10 && b <= 15)) decode_one(base ^ (32'h1 << b));
        decode_one('0);
        decode_one('1);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] wd;
            wd = $urandom;
            if (i % 2 == 0) begin
                wd[31:21] = 11'b11001110011;
                wd[15:10] = 6'b100000;
            end
            decode_one(wd);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule